// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is the integer add/subtract stage of a small 32-bit RISC core. Each cycle in which `op_valid` is high, it takes a destination register value, a source register value, a 5-bit instruction immediate and an operation code. One clock edge later it presents the computed value, a one-cycle destination write strobe, and updated zero, negative and carry flags. The register file, instruction fetch and the multiply/divide unit sit outside this block.

The operations are: plain, carry-chained and immediate ("quick") addition; plain, borrow-chained and immediate subtraction; register and immediate comparison; negation; and single-bit set and clear. The quick forms decode their immediate in two ways. Add and subtract treat a zero field as thirty-two. Compare treats the field as a signed number. On every subtraction-like operation the carry flag acts as a borrow. The carry flag the block holds is also the carry-in of the chained forms.

Top module: `addsub_flag_alu`

## Requirements
- R1: After any accepted operation with an assigned code, `flag_z` is 1 exactly when the 32-bit `result` is zero.
- R2: After any accepted operation with an assigned code, `flag_n` equals bit 31 of `result`.
- R3: For add (code 0) and add-quick (code 2), `flag_c` becomes 1 exactly when the unsigned sum of the two operands does not fit in 32 bits.
- R4: For subtract (3), subtract-quick (5), compare (6) and compare-quick (7), `result` is minuend minus subtrahend. `flag_c` becomes 1 exactly when the subtrahend is unsigned-greater than the minuend (a borrow). The minuend is `dst_val`.
- R5: For add-quick and subtract-quick, an `imm` of 0 stands for the value 32, and any other `imm` value stands for itself.
- R6: Compare-quick sign-extends `imm`, so values 16..31 stand for -16..-1. The extended value is used as a 32-bit unsigned subtrahend for the borrow.
- R7: Compare and compare-quick update all three flags and `result`, but never raise `wr_en`.
- R8: Negate (code 8) yields 0 minus `dst_val`. `flag_c` becomes 1 exactly when `dst_val` is nonzero.
- R9: Bit-set (9) and bit-clear (10) force bit `imm` of `dst_val` to 1 or 0 and leave every other bit as it is. They update `flag_z` and `flag_n` and leave `flag_c` unchanged.
- R10: Add-with-carry (1) computes `dst_val + src_val + C`, and subtract-with-borrow (4) computes `dst_val - src_val - C`, where C is the current `flag_c`. Their carry-out is the overflow or borrow of the whole three-term operation.
- R11: `wr_en` is high for exactly the one cycle after an accepted operation whose code is 0-5 or 8-10.
- R12: When `op_valid` is low, or the code is 11-15, `wr_en` stays low and `result` and the flags keep their values.
- R13: While `rst_n` is low, `result`, `wr_en` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| dst_val | input | 32 | Destination register value (minuend / first addend) |
| src_val | input | 32 | Source register value |
| imm | input | 5 | Instruction immediate or bit index |
| result | output | 32 | Computed value of the last accepted operation |
| wr_en | output | 1 | Destination write strobe |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The hardest cases to reach are the chained add and subtract at the ends of the operand range, for example 0 - 0 - 1 and 0xFFFFFFFF + 0xFFFFFFFF + 1. They depend on carry state that no input sets directly. Before each chained operation, the stimulus runs a preparatory add chosen to leave the carry at 0 or at 1, so every operand pair is tried with both carry-in values. Carry preservation by the bit operations is shown the same way: the carry is primed to each value first, and then every bit index is swept.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_ADDQ = 4'd2,
    OP_SUB  = 4'd3,
    OP_SBC  = 4'd4,
    OP_SUBQ = 4'd5,
    OP_CMP  = 4'd6,
    OP_CMPQ = 4'd7,
    OP_NEG  = 4'd8,
    OP_BSET = 4'd9,
    OP_BCLR = 4'd10
  } alu_op_e;

  function automatic logic op_assigned(logic [3:0] code);
    return code <= 4'd10;
  endfunction

  function automatic logic op_compare(logic [3:0] code);
    return (code == OP_CMP) || (code == OP_CMPQ);
  endfunction

  function automatic logic op_bitwise(logic [3:0] code);
    return (code == OP_BSET) || (code == OP_BCLR);
  endfunction

  function automatic logic op_subtract(logic [3:0] code);
    return (code == OP_SUB) || (code == OP_SBC) || (code == OP_SUBQ) ||
           (code == OP_CMP) || (code == OP_CMPQ) || (code == OP_NEG);
  endfunction

  function automatic logic op_chained(logic [3:0] code);
    return (code == OP_ADC) || (code == OP_SBC);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic [3:0]        code,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] lhs,
  output logic [DATA_W-1:0] rhs
);
  import alu_pkg::*;

  localparam int PAD_W = DATA_W - IMM_W;

  // zero field means 2**IMM_W, everything else is taken as-is
  function automatic logic [DATA_W-1:0] quick_unsigned(logic [IMM_W-1:0] f);
    logic [DATA_W-1:0] v;
    v = '0;
    v[IMM_W-1:0] = f;
    if (f == '0) v[IMM_W] = 1'b1;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] quick_signed(logic [IMM_W-1:0] f);
    return {{PAD_W{f[IMM_W-1]}}, f};
  endfunction

  always_comb begin
    lhs = dst;
    rhs = src;
    case (code)
      OP_ADDQ, OP_SUBQ: rhs = quick_unsigned(imm);
      OP_CMPQ:          rhs = quick_signed(imm);
      OP_NEG: begin
        lhs = '0;
        rhs = dst;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  logic              subtract,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int EXT_W = DATA_W + 1;

  function automatic logic [EXT_W-1:0] ext_add(logic [DATA_W-1:0] a,
                                               logic [DATA_W-1:0] b,
                                               logic c);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, c};
  endfunction

  // top bit of the extended difference is the borrow
  function automatic logic [EXT_W-1:0] ext_sub(logic [DATA_W-1:0] a,
                                               logic [DATA_W-1:0] b,
                                               logic c);
    return {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, c};
  endfunction

  logic [EXT_W-1:0] wide;

  always_comb begin
    if (subtract) wide = ext_sub(lhs, rhs, cin);
    else          wide = ext_add(lhs, rhs, cin);
  end

  assign sum  = wide[DATA_W-1:0];
  assign cout = wide[DATA_W];

endmodule

// File: rtl/alu_bitop.sv
module alu_bitop #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] value,
  input  logic [IMM_W-1:0]  index,
  input  logic              set_bit,
  output logic [DATA_W-1:0] out
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0] sel;
  assign sel = index[IDX_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign out[i] = (sel == IDX_W'(i)) ? set_bit : value[i];
  end

endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_c
);
  import alu_pkg::*;

  localparam int MSB = DATA_W - 1;

  // decoded events, also observed by the checker
  logic op_known, op_is_cmp, op_is_bit, op_is_sub, op_is_chain;
  logic accept, write_next;

  assign op_known    = op_assigned(op_code);
  assign op_is_cmp   = op_compare(op_code);
  assign op_is_bit   = op_bitwise(op_code);
  assign op_is_sub   = op_subtract(op_code);
  assign op_is_chain = op_chained(op_code);
  assign accept      = op_valid && op_known;
  assign write_next  = accept && !op_is_cmp;

  logic [DATA_W-1:0] lhs, rhs, arith_val, bit_val, next_val;
  logic              arith_c, next_c, carry_in;

  assign carry_in = op_is_chain ? flag_c : 1'b0;

  alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .code (op_code),
    .dst  (dst_val),
    .src  (src_val),
    .imm  (imm),
    .lhs  (lhs),
    .rhs  (rhs)
  );

  alu_addsub #(.DATA_W(DATA_W)) u_arith (
    .lhs      (lhs),
    .rhs      (rhs),
    .subtract (op_is_sub),
    .cin      (carry_in),
    .sum      (arith_val),
    .cout     (arith_c)
  );

  alu_bitop #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bit (
    .value   (dst_val),
    .index   (imm),
    .set_bit (op_code == OP_BSET),
    .out     (bit_val)
  );

  assign next_val = op_is_bit ? bit_val : arith_val;
  assign next_c   = op_is_bit ? flag_c  : arith_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      wr_en <= write_next;
      if (accept) begin
        result <= next_val;
        flag_z <= (next_val == '0);
        flag_n <= next_val[MSB];
        flag_c <= next_c;
      end
    end
  end

endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] dst_val,
  input logic [IMM_W-1:0]  imm,
  input logic              op_known,
  input logic              op_is_cmp,
  input logic              op_is_bit,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_c
);

  assert_zero_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_known) |=> (flag_z == (result == '0)));

  assert_neg_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_known) |=> (flag_n == result[DATA_W-1]));

  assert_quick_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd2 && imm == '0) |=>
      (result == $past(dst_val) + DATA_W'(32)));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_cmp) |=> !wr_en);

  assert_bit_keeps_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_bit) |=> (flag_c == $past(flag_c)));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_known) |=>
      (!wr_en && $stable(result) && $stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .dst_val   (dst_val),
  .imm       (imm),
  .op_known  (op_known),
  .op_is_cmp (op_is_cmp),
  .op_is_bit (op_is_bit),
  .result    (result),
  .wr_en     (wr_en),
  .flag_z    (flag_z),
  .flag_n    (flag_n),
  .flag_c    (flag_c)
);

// File: tb/sim_addsub_flag_alu.sv
module sim_addsub_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic [4:0]  imm = '0;
  logic [31:0] result;
  logic        wr_en, flag_z, flag_n, flag_c;

  always #5 clk = ~clk;

  addsub_flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .result(result), .wr_en(wr_en), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench-side state
  logic [31:0] m_res = '0;
  logic        m_z = 0, m_n = 0, m_c = 0;

  logic [31:0] edge_vals [5] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference arithmetic in 64-bit integers
  task automatic model(input int code, input logic [31:0] d, input logic [31:0] s,
                       input logic [4:0] q, output bit known, output bit writes,
                       output logic [31:0] r, output logic c);
    longint unsigned a, b, cin, t;
    known = (code <= 10);
    writes = known && code != 6 && code != 7;
    a = d; b = s; cin = 0; r = m_res; c = m_c;
    if (code == 1 || code == 4) cin = m_c;
    if (code == 2 || code == 5) b = (q == 0) ? 32 : q;
    if (code == 7) b = (q >= 16) ? (64'h1_0000_0000 - 32 + q) : q;
    if (code == 8) begin a = 0; b = d; end
    case (code)
      0, 1, 2: begin t = a + b + cin; r = t[31:0]; c = (t > 64'hFFFF_FFFF); end
      3, 4, 5, 6, 7, 8: begin r = 32'(a - b - cin); c = ((b + cin) > a); end
      9:  r = d | (32'h1 << q);
      10: r = d & ~(32'h1 << q);
      default: ;
    endcase
  endtask

  task automatic run_op(string req, int code, logic [31:0] d, logic [31:0] s, logic [4:0] q);
    bit known, writes; logic [31:0] r; logic c;
    model(code, d, s, q, known, writes, r, c);
    @(negedge clk);
    op_valid = 1; op_code = 4'(code); dst_val = d; src_val = s; imm = q;
    @(negedge clk);
    op_valid = 0;
    if (known) begin
      m_res = r; m_c = c; m_z = (r == 0); m_n = r[31];
    end
    chk({req, " R11 wr_en"}, wr_en, writes);
    chk({req, " result"}, result, m_res);
    chk({req, " R1 zero"}, flag_z, m_z);
    chk({req, " R2 neg"}, flag_n, m_n);
    chk({req, " carry"}, flag_c, m_c);
  endtask

  task automatic prime_carry(bit v);
    if (v) run_op("R3 prime", 0, 32'hFFFF_FFFF, 32'h1, 0);
    else   run_op("R3 prime", 0, 32'h0, 32'h0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R13 reset state
    chk("R13 result", result, 0);
    chk("R13 wr_en", wr_en, 0);
    chk("R13 flags", {flag_z, flag_n, flag_c}, 0);
    rst_n = 1;

    // R3 R4 R7 plain ops on boundary pairs
    foreach (edge_vals[i]) foreach (edge_vals[j]) begin
      run_op("R3 add", 0, edge_vals[i], edge_vals[j], 0);
      run_op("R4 sub", 3, edge_vals[i], edge_vals[j], 0);
      run_op("R7 cmp", 6, edge_vals[i], edge_vals[j], 0);
    end
    // R10 chained ops with each carry-in
    for (int cv = 0; cv < 2; cv++)
      foreach (edge_vals[i]) foreach (edge_vals[j]) begin
        prime_carry(cv[0]);
        run_op("R10 adc", 1, edge_vals[i], edge_vals[j], 0);
        prime_carry(cv[0]);
        run_op("R10 sbc", 4, edge_vals[i], edge_vals[j], 0);
      end
    // R5 R6 quick immediates, full sweep
    for (int q = 0; q < 32; q++) begin
      run_op("R5 addq", 2, 32'hFFFF_FFE5, 0, 5'(q));
      run_op("R5 subq", 5, 32'h0000_0010, 0, 5'(q));
      run_op("R6 cmpq", 7, 32'h0000_0003, 0, 5'(q));
      run_op("R6 cmpq", 7, 32'hFFFF_FFF5, 0, 5'(q));
    end
    // R8 negate
    foreach (edge_vals[i]) run_op("R8 neg", 8, edge_vals[i], 32'h1234_5678, 0);
    // R9 bit ops with both carry states
    for (int cv = 0; cv < 2; cv++)
      for (int q = 0; q < 32; q++) begin
        prime_carry(cv[0]);
        run_op("R9 bset", 9, 32'h0, 0, 5'(q));
        run_op("R9 bclr", 10, 32'hFFFF_FFFF, 0, 5'(q));
        run_op("R9 bclr", 10, 32'h1 << q, 0, 5'(q));
      end
    // R12 unassigned codes and idle cycles leave state untouched
    prime_carry(1);
    run_op("R3 set", 0, 32'h8000_0000, 32'h8000_0001, 0);
    for (int k = 11; k < 16; k++) run_op("R12 unassigned", k, 32'h5, 32'h5, 5'd3);
    repeat (3) @(negedge clk);
    chk("R12 idle wr_en", wr_en, 0);
    chk("R12 idle result", result, m_res);
    chk("R12 idle flags", {flag_z, flag_n, flag_c}, {m_z, m_n, m_c});

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule